// File: doc/BRIEF.md
# Display Controller Serial Slave Front End

This block is the bus-facing front end of a display controller. It watches the two lines of an I2C bus, finds START and STOP conditions, recognises its own 7-bit device address and acknowledges the bytes meant for it. In a write, the bytes after the address are split into control bytes and payload bytes. Each payload byte is sent either to the command decoder as a one-cycle strobe or to display RAM as a write at an internal pointer that then steps forward.

In a read, the block shifts bytes out straight after the address acknowledge. The source of these bytes is display RAM when the most recent write selected RAM, and a status byte otherwise. The command decoder, the RAM array and the status source sit outside this block. They are reached through plain strobe, address and data ports. SDA is driven open-drain: `sda_oe` high means the pad pulls the line low.

Top module: `dsp_i2c_front`

## Requirements
- R1: The device answers to the 7-bit address `011110` followed by the level on `addr_lsb`. The eighth bit of the address byte is the direction bit, where 1 means read. A matching address is acknowledged by pulling SDA low during the ninth clock.
- R2: An address that does not match gets no acknowledge. Every later byte up to the next START is ignored: no acknowledge, no command strobe and no RAM write.
- R3: A control byte carries the continuation flag in bit 7 and the route flag in bit 6. While the continuation flag is 1, the write stream alternates between a control byte and a payload byte.
- R4: After a control byte whose continuation flag is 0, every following byte up to STOP or a repeated START is a payload byte routed by that control byte.
- R5: A payload byte with route flag 1 produces a one-cycle `ram_we` with the byte on `ram_wdata` and the current pointer on `ram_addr`. With route flag 0 it produces a one-cycle `cmd_valid` with the byte on `cmd_byte`.
- R6: Every address, control and payload byte of an addressed write is acknowledged.
- R7: A read returns RAM data at the pointer when the last received route flag is 1, and `status_byte` when it is 0. The route flag is 0 after reset and is kept across STOP. Each RAM byte sent advances the pointer by one.
- R8: When the master does not acknowledge a read byte, the block releases SDA and drives nothing more until the next START.
- R9: The pointer steps from DEPTH-1 to 0. A one-cycle `ptr_load` sets it to `ptr_value` on the next cycle, and a load takes priority over a step.
- R10: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. STOP releases SDA and returns the block to idle. A repeated START makes the next byte an address byte again.
- R11: `sda_oe` only rises while the synchronised SCL is low.
- R12: After reset, `sda_oe`, `ram_we` and `cmd_valid` are 0 and `ram_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_oe | output | 1 | Pull SDA low when 1 |
| addr_lsb | input | 1 | Level that sets the low address bit |
| cmd_valid | output | 1 | Command byte strobe |
| cmd_byte | output | 8 | Command byte |
| ram_we | output | 1 | Display RAM write strobe |
| ram_addr | output | AW | Display RAM pointer, used for both writes and reads |
| ram_wdata | output | 8 | Display RAM write data |
| ram_rdata | input | 8 | Display RAM read data (synchronous read) |
| status_byte | input | 8 | Byte returned by reads while the route flag is 0 |
| ptr_load | input | 1 | Load the pointer |
| ptr_value | input | AW | Value to load into the pointer |

## Verification
The bench checks the pointer wrap inside a long payload stream. A design that missed the wrap would write past DEPTH-1 or would stall. It reads back after a STOP to check that the route flag survived; a design that cleared it would return the status byte instead of RAM data. After a negative acknowledge from the master, the bench clocks one more byte and expects all ones; a slave that kept driving would corrupt that byte. The bench also sends a repeated START in the middle of a payload stream and expects the next byte after the address to be taken as a control byte; a parser that did not reset would write that byte into RAM. Finally, a non-matching address is followed by more bytes, which must produce no acknowledge and no strobe.

// File: rtl/dsp_i2c_pkg.sv
package dsp_i2c_pkg;

  localparam int BYTE_W = 8;
  localparam int BCNT_W = $clog2(BYTE_W + 1);
  localparam logic [5:0] DEV_ID_HI = 6'b011110;

  typedef enum logic [2:0] {
    LK_IDLE,
    LK_RX,
    LK_RXEND,
    LK_ACK,
    LK_TX,
    LK_MACK
  } link_st_t;

  typedef enum logic [2:0] {
    FR_IDLE,
    FR_ADDR,
    FR_CTRL,
    FR_PAIR,
    FR_STREAM,
    FR_READ,
    FR_SKIP
  } frame_st_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_prev;
  logic              sda_prev;

  // Idle bus is high, so reset to ones to avoid a false START.
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_raw};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_raw};
      scl_prev <= scl_pipe[STAGES-1];
      sda_prev <= sda_pipe[STAGES-1];
    end
  end

  assign scl_lvl   = scl_pipe[STAGES-1];
  assign sda_lvl   = sda_pipe[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_prev;
  assign scl_fall  = ~scl_lvl & scl_prev;
  assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;

endmodule

// File: rtl/i2c_link.sv
module i2c_link
  import dsp_i2c_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_lvl,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              accept,
  input  logic              read_mode,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              sda_oe,
  output logic              rx_valid,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              tx_done
);

  link_st_t          state;
  logic [BCNT_W-1:0] bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic              mack;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= LK_IDLE;
      bit_cnt  <= '0;
      shreg    <= '0;
      sda_oe   <= 1'b0;
      rx_valid <= 1'b0;
      rx_byte  <= '0;
      tx_done  <= 1'b0;
      mack     <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      tx_done  <= 1'b0;
      if (start_det) begin
        state   <= LK_RX;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
      end else if (stop_det) begin
        state  <= LK_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          LK_RX: begin
            if (scl_rise) begin
              shreg <= {shreg[BYTE_W-2:0], sda_lvl};
              if (bit_cnt == BCNT_W'(BYTE_W - 1)) begin
                rx_valid <= 1'b1;
                rx_byte  <= {shreg[BYTE_W-2:0], sda_lvl};
                bit_cnt  <= '0;
                state    <= LK_RXEND;
              end else begin
                bit_cnt <= bit_cnt + 1'b1;
              end
            end
          end
          LK_RXEND: begin
            if (scl_fall) begin
              if (accept) begin
                sda_oe <= 1'b1;
                state  <= LK_ACK;
              end else begin
                state <= LK_IDLE;
              end
            end
          end
          LK_ACK: begin
            if (scl_fall) begin
              bit_cnt <= '0;
              if (read_mode) begin
                shreg  <= tx_byte;
                sda_oe <= ~tx_byte[BYTE_W-1];
                state  <= LK_TX;
              end else begin
                sda_oe <= 1'b0;
                state  <= LK_RX;
              end
            end
          end
          LK_TX: begin
            if (scl_rise) begin
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall) begin
              if (bit_cnt == BCNT_W'(BYTE_W)) begin
                sda_oe <= 1'b0;
                state  <= LK_MACK;
              end else begin
                sda_oe <= ~shreg[BYTE_W-2];
                shreg  <= {shreg[BYTE_W-2:0], 1'b0};
              end
            end
          end
          LK_MACK: begin
            if (scl_rise) begin
              mack    <= ~sda_lvl;
              tx_done <= 1'b1;
            end else if (scl_fall) begin
              bit_cnt <= '0;
              if (mack) begin
                shreg  <= tx_byte;
                sda_oe <= ~tx_byte[BYTE_W-1];
                state  <= LK_TX;
              end else begin
                state <= LK_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/frame_ctrl.sv
module frame_ctrl
  import dsp_i2c_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              addr_lsb,
  output logic              accept,
  output logic              read_mode,
  output logic              dc_sel,
  output logic              wr_ram,
  output logic              wr_cmd,
  output logic [BYTE_W-1:0] data_q
);

  frame_st_t state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= FR_IDLE;
      accept    <= 1'b1;
      read_mode <= 1'b0;
      dc_sel    <= 1'b0;
      wr_ram    <= 1'b0;
      wr_cmd    <= 1'b0;
      data_q    <= '0;
    end else begin
      wr_ram <= 1'b0;
      wr_cmd <= 1'b0;
      if (start_det) begin
        state     <= FR_ADDR;
        accept    <= 1'b1;
        read_mode <= 1'b0;
      end else if (stop_det) begin
        state     <= FR_IDLE;
        read_mode <= 1'b0;
      end else if (rx_valid) begin
        case (state)
          FR_ADDR: begin
            if (rx_byte[BYTE_W-1:1] == {DEV_ID_HI, addr_lsb}) begin
              accept    <= 1'b1;
              read_mode <= rx_byte[0];
              state     <= rx_byte[0] ? FR_READ : FR_CTRL;
            end else begin
              accept <= 1'b0;
              state  <= FR_SKIP;
            end
          end
          FR_CTRL: begin
            // bit 7: continuation, bit 6: route (1 = RAM)
            dc_sel <= rx_byte[6];
            state  <= rx_byte[7] ? FR_PAIR : FR_STREAM;
          end
          FR_PAIR, FR_STREAM: begin
            data_q <= rx_byte;
            if (dc_sel) wr_ram <= 1'b1;
            else        wr_cmd <= 1'b1;
            if (state == FR_PAIR) state <= FR_CTRL;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/disp_ptr.sv
module disp_ptr #(
  parameter int DEPTH = 128,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          advance,
  output logic [AW-1:0] ptr
);

  logic [AW-1:0] nxt;

  generate
    if (DEPTH == (1 << AW)) begin : g_pow2
      assign nxt = ptr + 1'b1;
    end else begin : g_cmp
      assign nxt = (ptr == AW'(DEPTH - 1)) ? '0 : ptr + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)          ptr <= '0;
    else if (load)    ptr <= load_val;
    else if (advance) ptr <= nxt;
  end

endmodule

// File: rtl/dsp_i2c_front.sv
module dsp_i2c_front
  import dsp_i2c_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int SYNC_STAGES = 2,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_oe,
  input  logic              addr_lsb,
  output logic              cmd_valid,
  output logic [BYTE_W-1:0] cmd_byte,
  output logic              ram_we,
  output logic [AW-1:0]     ram_addr,
  output logic [BYTE_W-1:0] ram_wdata,
  input  logic [BYTE_W-1:0] ram_rdata,
  input  logic [BYTE_W-1:0] status_byte,
  input  logic              ptr_load,
  input  logic [AW-1:0]     ptr_value
);

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic accept, read_mode, dc_sel, rx_valid, tx_done;
  logic [BYTE_W-1:0] rx_byte, tx_byte, data_q;
  logic ptr_adv;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_raw(scl_in), .sda_raw(sda_in),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  assign tx_byte = dc_sel ? ram_rdata : status_byte;

  i2c_link u_link (
    .clk(clk), .rst(rst), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_lvl(sda_lvl), .start_det(start_det), .stop_det(stop_det),
    .accept(accept), .read_mode(read_mode), .tx_byte(tx_byte),
    .sda_oe(sda_oe), .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_done(tx_done)
  );

  frame_ctrl u_frame (
    .clk(clk), .rst(rst), .start_det(start_det), .stop_det(stop_det),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .addr_lsb(addr_lsb),
    .accept(accept), .read_mode(read_mode), .dc_sel(dc_sel),
    .wr_ram(ram_we), .wr_cmd(cmd_valid), .data_q(data_q)
  );

  assign ptr_adv = ram_we | (tx_done & dc_sel);

  disp_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst(rst), .load(ptr_load), .load_val(ptr_value),
    .advance(ptr_adv), .ptr(ram_addr)
  );

  assign cmd_byte  = data_q;
  assign ram_wdata = data_q;

endmodule

// File: rtl/dsp_i2c_front_chk.sv
module dsp_i2c_front_chk #(
  parameter int DEPTH = 128,
  parameter int AW = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          scl_lvl,
  input logic          stop_det,
  input logic          sda_oe,
  input logic          ram_we,
  input logic          cmd_valid,
  input logic [AW-1:0] ram_addr,
  input logic          ptr_load,
  input logic [AW-1:0] ptr_value,
  input logic          tx_done,
  input logic          dc_sel
);

  function automatic logic [AW-1:0] step(input logic [AW-1:0] a);
    return (a == AW'(DEPTH - 1)) ? '0 : a + 1'b1;
  endfunction

  assert_oe_rise_scl_low_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !$past(scl_lvl));

  assert_stop_release_R10: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe);

  assert_ptr_wrap_R9: assert property (@(posedge clk) disable iff (rst)
    (ram_we && !ptr_load) |=> ram_addr == step($past(ram_addr)));

  assert_ptr_load_R9: assert property (@(posedge clk) disable iff (rst)
    ptr_load |=> ram_addr == $past(ptr_value));

  assert_ptr_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!ram_we && !ptr_load && !(tx_done && dc_sel)) |=> $stable(ram_addr));

  assert_cmd_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid);

  assert_ram_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    ram_we |=> !ram_we);

endmodule

bind dsp_i2c_front dsp_i2c_front_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .scl_lvl(scl_lvl), .stop_det(stop_det),
  .sda_oe(sda_oe), .ram_we(ram_we), .cmd_valid(cmd_valid),
  .ram_addr(ram_addr), .ptr_load(ptr_load), .ptr_value(ptr_value),
  .tx_done(tx_done), .dc_sel(dc_sel)
);

// File: tb/tb_dsp_i2c_front.sv
module tb_dsp_i2c_front;
  localparam int DEPTH = 8;
  localparam int AW = 3;
  localparam int H = 8;
  localparam logic [7:0] STATUS = 8'hC7;
  // {control byte, payload byte}; control bit7 = continuation, bit6 = route to RAM
  localparam logic [15:0] VEC [6] = '{16'hC011, 16'h80A5, 16'hC022,
                                       16'hC033, 16'h803C, 16'hC044};

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, scl_m, sda_m, addr_lsb, ptr_load;
  logic [AW-1:0] ptr_value;
  logic [7:0] ram_rdata, status_byte;
  logic sda_oe, cmd_valid, ram_we;
  logic [7:0] cmd_byte, ram_wdata;
  logic [AW-1:0] ram_addr;
  wire sda_line = sda_m & ~sda_oe;

  dsp_i2c_front #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_line), .sda_oe(sda_oe),
    .addr_lsb(addr_lsb), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_rdata(ram_rdata), .status_byte(status_byte),
    .ptr_load(ptr_load), .ptr_value(ptr_value)
  );

  logic [7:0] env_mem [DEPTH];
  always @(posedge clk) begin
    if (ram_we) env_mem[ram_addr] <= ram_wdata;
    ram_rdata <= env_mem[ram_addr];
  end

  int total = 0, bad = 0;
  int n_ram = 0, n_cmd = 0, oe_bad = 0;
  logic oe_prev = 1'b0;
  logic [AW-1:0] lg_addr [32];
  logic [7:0] lg_wd [32];
  logic [7:0] lg_cmd [32];
  logic [7:0] exp_mem [DEPTH];
  int exp_ptr = 0;

  always @(negedge clk) begin
    if (ram_we && n_ram < 32) begin lg_addr[n_ram] = ram_addr; lg_wd[n_ram] = ram_wdata; n_ram++; end
    if (cmd_valid && n_cmd < 32) begin lg_cmd[n_cmd] = cmd_byte; n_cmd++; end
    if (sda_oe && !oe_prev && scl_m) oe_bad++;
    oe_prev = sda_oe;
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic hp(); repeat (H) @(negedge clk); endtask
  task automatic bus_start(); sda_m = 1; hp(); scl_m = 1; hp(); sda_m = 0; hp(); scl_m = 0; hp(); endtask
  task automatic bus_stop(); sda_m = 0; hp(); scl_m = 1; hp(); sda_m = 1; hp(); endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hp(); scl_m = 1; hp(); scl_m = 0; hp();
    end
    sda_m = 1; hp(); scl_m = 1; hp(); acked = ~sda_line; scl_m = 0; hp();
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      scl_m = 1; hp(); b[i] = sda_line; scl_m = 0; hp();
    end
    sda_m = ~give_ack; hp(); scl_m = 1; hp(); scl_m = 0; hp(); sda_m = 1;
  endtask

  task automatic clear_logs(); n_ram = 0; n_cmd = 0; endtask

  task automatic exp_ram(input int idx, input logic [7:0] d, input string req);
    chk(req, "ram write address", 32'(lg_addr[idx]), 32'(exp_ptr));
    chk(req, "ram write data", 32'(lg_wd[idx]), 32'(d));
    exp_mem[exp_ptr] = d;
    exp_ptr = (exp_ptr + 1) % DEPTH;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] rb;
    int nak;
    int ri;
    int ci;
    for (int i = 0; i < DEPTH; i++) begin env_mem[i] = 8'h00; exp_mem[i] = 8'h00; end
    rst = 1; scl_m = 1; sda_m = 1; addr_lsb = 0; ptr_load = 0; ptr_value = '0;
    status_byte = STATUS;
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R12", "sda_oe after reset", 32'(sda_oe), 0);
    chk("R12", "ram_we after reset", 32'(ram_we), 0);
    chk("R12", "cmd_valid after reset", 32'(cmd_valid), 0);
    chk("R12", "ram_addr after reset", 32'(ram_addr), 0);

    // R7: route flag is 0 after reset, so a read returns the status byte
    bus_start(); send_byte(8'h79, ack);
    chk("R1", "read address ack", 32'(ack), 1);
    recv_byte(1'b0, rb); bus_stop();
    chk("R7", "read after reset gives status", 32'(rb), 32'(STATUS));

    // Vector table: control/payload pairs with continuation set (R3, R5, R6)
    clear_logs(); nak = 0;
    bus_start(); send_byte(8'h78, ack); if (!ack) nak++;
    for (int v = 0; v < 6; v++) begin
      send_byte(VEC[v][15:8], ack); if (!ack) nak++;
      send_byte(VEC[v][7:0], ack); if (!ack) nak++;
    end
    bus_stop();
    chk("R6", "missing acks in paired write", 32'(nak), 0);
    chk("R3", "ram write count", 32'(n_ram), 4);
    chk("R3", "command count", 32'(n_cmd), 2);
    ri = 0; ci = 0;
    for (int v = 0; v < 6; v++) begin
      if (VEC[v][14]) begin exp_ram(ri, VEC[v][7:0], "R5"); ri++; end
      else begin chk("R5", "command byte", 32'(lg_cmd[ci]), 32'(VEC[v][7:0])); ci++; end
    end

    // Stream after continuation 0, crossing the pointer wrap (R4, R9)
    clear_logs(); nak = 0;
    bus_start(); send_byte(8'h78, ack); if (!ack) nak++;
    send_byte(8'h40, ack); if (!ack) nak++;
    for (int k = 0; k < 6; k++) begin send_byte(8'h50 + 8'(k), ack); if (!ack) nak++; end
    bus_stop();
    chk("R6", "missing acks in stream write", 32'(nak), 0);
    chk("R4", "stream ram write count", 32'(n_ram), 6);
    for (int k = 0; k < 6; k++) exp_ram(k, 8'h50 + 8'(k), "R9");

    // Pointer load (R9)
    @(negedge clk); ptr_load = 1; ptr_value = 3'd5;
    @(negedge clk); ptr_load = 0;
    chk("R9", "pointer after load", 32'(ram_addr), 5);
    exp_ptr = 5;
    clear_logs();
    bus_start(); send_byte(8'h78, ack); send_byte(8'h40, ack); send_byte(8'h66, ack); bus_stop();
    chk("R9", "writes after load", 32'(n_ram), 1);
    exp_ram(0, 8'h66, "R9");

    // Read from RAM with the route flag kept across STOP; NACK ends it (R7, R8)
    bus_start(); send_byte(8'h79, ack);
    recv_byte(1'b1, rb);
    chk("R7", "ram read byte 0", 32'(rb), 32'(exp_mem[exp_ptr]));
    exp_ptr = (exp_ptr + 1) % DEPTH;
    recv_byte(1'b0, rb);
    chk("R7", "ram read byte 1", 32'(rb), 32'(exp_mem[exp_ptr]));
    exp_ptr = (exp_ptr + 1) % DEPTH;
    recv_byte(1'b0, rb);
    chk("R8", "bus released after master nack", 32'(rb), 32'hFF);
    bus_stop();
    chk("R7", "pointer after ram reads", 32'(ram_addr), 32'(exp_ptr));

    // Address mismatch: no ack, later bytes ignored (R1, R2)
    clear_logs();
    bus_start(); send_byte(8'h7A, ack);
    chk("R1", "mismatched address ack", 32'(ack), 0);
    send_byte(8'h00, ack);
    chk("R2", "ack on ignored byte", 32'(ack), 0);
    send_byte(8'h77, ack); bus_stop();
    chk("R2", "strobes after mismatch", 32'(n_ram + n_cmd), 0);

    // Low address bit follows addr_lsb (R1); command route (R5)
    addr_lsb = 1; clear_logs();
    bus_start(); send_byte(8'h78, ack); bus_stop();
    chk("R1", "old address ignored with addr_lsb=1", 32'(ack), 0);
    bus_start(); send_byte(8'h7A, ack);
    chk("R1", "address ack with addr_lsb=1", 32'(ack), 1);
    send_byte(8'h00, ack); send_byte(8'h9E, ack); bus_stop();
    chk("R5", "command count", 32'(n_cmd), 1);
    chk("R5", "command byte", 32'(lg_cmd[0]), 32'h9E);

    // Route flag 0 kept across STOP: read returns status, pointer holds (R7)
    bus_start(); send_byte(8'h7B, ack); recv_byte(1'b0, rb); bus_stop();
    chk("R7", "status read", 32'(rb), 32'(STATUS));
    chk("R7", "pointer unchanged by status read", 32'(ram_addr), 32'(exp_ptr));

    // Repeated START in a stream restarts framing (R10)
    clear_logs();
    bus_start(); send_byte(8'h7A, ack); send_byte(8'h40, ack); send_byte(8'h81, ack);
    bus_start(); send_byte(8'h7A, ack);
    chk("R10", "address ack after repeated start", 32'(ack), 1);
    send_byte(8'h00, ack); send_byte(8'h5A, ack); bus_stop();
    chk("R10", "ram writes across repeated start", 32'(n_ram), 1);
    exp_ram(0, 8'h81, "R10");
    chk("R10", "command after repeated start", 32'(n_cmd), 1);
    chk("R10", "command byte after repeated start", 32'(lg_cmd[0]), 32'h5A);
    chk("R10", "sda released after stop", 32'(sda_oe), 0);

    chk("R11", "sda_oe rises seen with SCL high", 32'(oe_bad), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule